// File: doc/BRIEF.md
# Two-Level Branch Target Predictor

This block is a set-associative branch target buffer that the fetch stage consults once per fetch address. A valid entry whose tag and in-line offset match the address gives a taken or not-taken call and a target. The call comes from a table of 2-bit saturating counters owned by the set and indexed by a 4-bit local history held in the hitting entry. When no way matches, the block reports a miss and fetch continues sequentially.

Each entry keeps two local histories. The speculative one advances at prediction time, so a second instance of the same branch that is already in flight sees the call made for the first. The committed one advances only when the branch resolves in execution. The counters are trained only at resolve. A mispredicted resolve copies the committed history over the speculative one. A resolving branch that is not in the buffer replaces the way in its set that was resolved least recently.

Address layout with the default parameters: bits [3:0] are the branch offset within a 16-byte fetch line, bits [10:4] select one of 128 sets, and bits [31:11] form the tag. There are 4 ways per set, 512 entries in all.

Top module: `btb_two_level`

## Requirements
- R1: After reset, pred_valid is 0, every entry is invalid, and every counter holds 1 (weakly not taken).
- R2: A lookup presented with lk_valid high gives its result on the next clock edge: pred_valid is 1 in that cycle, and 0 in any cycle that follows a clock with lk_valid low.
- R3: A lookup that matches no valid way in its set returns pred_hit=0, pred_taken=0 and pred_next = lk_addr + 4.
- R4: A lookup hits when a valid way in set lk_addr[10:4] holds tag lk_addr[31:11] and offset lk_addr[3:0]. pred_taken is 1 when the selected counter is 2 or 3. pred_next is then the stored target, and lk_addr + 4 otherwise. At most one way of a set matches any address.
- R5: The counter index is the entry's speculative history while its speculative-valid flag is set, and its committed history otherwise.
- R6: A hitting lookup shifts its predicted outcome (1 = taken) into bit 0 of that entry's speculative history, using the history it indexed with as the base, and sets the speculative-valid flag.
- R7: A resolve that hits adjusts the counter at the entry's committed history by +1 if taken or -1 if not, saturating at 0 and 3. It shifts the outcome into bit 0 of the committed history and, when taken, replaces the stored target with rs_target.
- R8: A resolve with rs_mispredict set overwrites the speculative history with the updated committed history and clears the speculative-valid flag.
- R9: Lookups never change any counter.
- R10: A resolve that misses writes tag, offset and rs_target into a way of its set, with both histories zero and the speculative flag clear. No counter changes.
- R11: Recency is updated only by resolves, whether they hit or allocate. The way replaced is the one whose last resolve is oldest, so a fifth distinct branch resolved into a full set evicts the earliest of the four.
- R12: A lookup and a resolve in the same cycle both see the state from before the edge. When both touch the same entry, the resolve's writes take effect over the lookup's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Fetch address to look up |
| rs_valid | input | 1 | Resolved branch this cycle |
| rs_addr | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |
| rs_target | input | 32 | Actual target of the resolved branch |
| rs_mispredict | input | 1 | The resolved branch was mispredicted |
| pred_valid | output | 1 | A lookup result is present |
| pred_hit | output | 1 | The lookup matched an entry |
| pred_taken | output | 1 | Predicted taken |
| pred_next | output | 32 | Next fetch address: target if taken, else lookup address + 4 |

## Verification
Every lookup result is registered and due exactly one clock after the edge that captured the lookup. The state changes from a resolve are visible to a lookup driven in the following cycle. The bench changes inputs on the falling edge, so the rising edge between captures them, and it compares the outputs at the next falling edge against a model updated in the same order as the hardware: lookup read, speculative shift, then resolve. Directed sequences separate the speculative and committed histories, force a mispredict recovery, and fill a set beyond four ways. Random traffic then concentrates on two sets with overlapping lookups and resolves.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int ADDR_W = 32;
    localparam int OFF_W  = 4;
    localparam int SETS   = 128;
    localparam int WAYS   = 4;
    localparam int HIST_W = 4;
    localparam int CTR_W  = 2;

    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int PHT_N  = 1 << HIST_W;

    localparam logic [CTR_W-1:0]  CTR_INIT = CTR_W'(1);
    localparam logic [CTR_W-1:0]  CTR_THR  = CTR_W'(1 << (CTR_W - 1));
    localparam logic [CTR_W-1:0]  CTR_MAX  = {CTR_W{1'b1}};
    localparam logic [ADDR_W-1:0] FALL_STEP = ADDR_W'(4);

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [OFF_W-1:0]  boff;
        logic [ADDR_W-1:0] tgt;
        logic [HIST_W-1:0] chist;
        logic [HIST_W-1:0] shist;
        logic              sval;
    } slot_t;

    function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
        return a[OFF_W-1:0];
    endfunction

    function automatic logic [HIST_W-1:0] f_shift(input logic [HIST_W-1:0] h,
                                                  input logic b);
        return {h[HIST_W-2:0], b};
    endfunction

    function automatic logic [CTR_W-1:0] f_ctr_next(input logic [CTR_W-1:0] c,
                                                    input logic up);
        if (up)
            return (c == CTR_MAX) ? c : c + CTR_W'(1);
        else
            return (c == '0) ? c : c - CTR_W'(1);
    endfunction

endpackage

// File: rtl/btb_way_match.sv
module btb_way_match
    import btb_pkg::*;
#(
    parameter int NWAYS = WAYS,
    localparam int NW_W = $clog2(NWAYS)
) (
    input  slot_t [NWAYS-1:0] row,
    input  logic [TAG_W-1:0]  tag,
    input  logic [OFF_W-1:0]  off,
    output logic [NWAYS-1:0]  hit_vec,
    output logic              hit,
    output logic [NW_W-1:0]   hit_way
);

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign hit_vec[w] = row[w].vld && (row[w].tag == tag) && (row[w].boff == off);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = NW_W'(w);
        end
    end

endmodule

// File: rtl/btb_lru.sv
module btb_lru
    import btb_pkg::*;
#(
    parameter int NSETS = SETS,
    parameter int NWAYS = WAYS,
    localparam int NS_W = $clog2(NSETS),
    localparam int NW_W = $clog2(NWAYS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            touch_en,
    input  logic [NS_W-1:0] touch_set,
    input  logic [NW_W-1:0] touch_way,
    input  logic [NS_W-1:0] qry_set,
    output logic [NW_W-1:0] victim_way
);

    logic [NW_W-1:0] age [NSETS][NWAYS];

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (age[qry_set][w] == NW_W'(NWAYS - 1)) victim_way = NW_W'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++)
                for (int w = 0; w < NWAYS; w++)
                    age[s][w] <= NW_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (NW_W'(w) == touch_way)
                    age[touch_set][w] <= '0;
                else if (age[touch_set][w] < age[touch_set][touch_way])
                    age[touch_set][w] <= age[touch_set][w] + NW_W'(1);
            end
        end
    end

endmodule

// File: rtl/btb_pht.sv
module btb_pht
    import btb_pkg::*;
#(
    parameter int NSETS = SETS,
    localparam int NS_W = $clog2(NSETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NS_W-1:0]   rd_set,
    input  logic [HIST_W-1:0] rd_hist,
    output logic [CTR_W-1:0]  rd_ctr,
    input  logic              wr_en,
    input  logic [NS_W-1:0]   wr_set,
    input  logic [HIST_W-1:0] wr_hist,
    input  logic              wr_taken
);

    logic [CTR_W-1:0] ctr [NSETS][PHT_N];

    assign rd_ctr = ctr[rd_set][rd_hist];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++)
                for (int h = 0; h < PHT_N; h++)
                    ctr[s][h] <= CTR_INIT;
        end else if (wr_en) begin
            ctr[wr_set][wr_hist] <= f_ctr_next(ctr[wr_set][wr_hist], wr_taken);
        end
    end

endmodule

// File: rtl/btb_two_level.sv
module btb_two_level
    import btb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_addr,
    input  logic              rs_taken,
    input  logic [ADDR_W-1:0] rs_target,
    input  logic              rs_mispredict,
    output logic              pred_valid,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_next
);

    slot_t tbl [SETS][WAYS];

    // lookup path
    logic [IDX_W-1:0]  lk_set;
    slot_t [WAYS-1:0]  lk_row;
    logic [WAYS-1:0]   lk_hitv;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    slot_t             lk_slot;
    logic [HIST_W-1:0] lk_hist;
    logic [CTR_W-1:0]  lk_ctr;
    logic              lk_tk;

    // resolve path
    logic [IDX_W-1:0]  rs_set;
    slot_t [WAYS-1:0]  rs_row;
    logic [WAYS-1:0]   rs_hitv;
    logic              rs_hit;
    logic [WAY_W-1:0]  rs_way;
    logic [WAY_W-1:0]  rs_victim;
    logic [WAY_W-1:0]  rs_wway;
    slot_t             rs_slot;
    logic [HIST_W-1:0] rs_chist_n;
    slot_t             rs_fresh;

    assign lk_set = f_idx(lk_addr);
    assign rs_set = f_idx(rs_addr);

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_row[w] = tbl[lk_set][w];
            rs_row[w] = tbl[rs_set][w];
        end
    end

    btb_way_match #(.NWAYS(WAYS)) u_lk_match (
        .row     (lk_row),
        .tag     (f_tag(lk_addr)),
        .off     (f_off(lk_addr)),
        .hit_vec (lk_hitv),
        .hit     (lk_hit),
        .hit_way (lk_way)
    );

    btb_way_match #(.NWAYS(WAYS)) u_rs_match (
        .row     (rs_row),
        .tag     (f_tag(rs_addr)),
        .off     (f_off(rs_addr)),
        .hit_vec (rs_hitv),
        .hit     (rs_hit),
        .hit_way (rs_way)
    );

    assign lk_slot = lk_row[lk_way];
    assign lk_hist = lk_slot.sval ? lk_slot.shist : lk_slot.chist;
    assign lk_tk   = lk_hit && (lk_ctr >= CTR_THR);

    assign rs_slot    = rs_row[rs_way];
    assign rs_chist_n = f_shift(rs_slot.chist, rs_taken);
    assign rs_wway    = rs_hit ? rs_way : rs_victim;

    always_comb begin
        rs_fresh       = '0;
        rs_fresh.vld   = 1'b1;
        rs_fresh.tag   = f_tag(rs_addr);
        rs_fresh.boff  = f_off(rs_addr);
        rs_fresh.tgt   = rs_target;
    end

    btb_pht #(.NSETS(SETS)) u_pht (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (lk_set),
        .rd_hist  (lk_hist),
        .rd_ctr   (lk_ctr),
        .wr_en    (rs_valid && rs_hit),
        .wr_set   (rs_set),
        .wr_hist  (rs_slot.chist),
        .wr_taken (rs_taken)
    );

    btb_lru #(.NSETS(SETS), .NWAYS(WAYS)) u_lru (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (rs_valid),
        .touch_set  (rs_set),
        .touch_way  (rs_wway),
        .qry_set    (rs_set),
        .victim_way (rs_victim)
    );

    // entry state: lookup writes first, resolve writes override
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    tbl[s][w] <= '0;
        end else begin
            if (lk_valid && lk_hit) begin
                tbl[lk_set][lk_way].shist <= f_shift(lk_hist, lk_tk);
                tbl[lk_set][lk_way].sval  <= 1'b1;
            end
            if (rs_valid) begin
                if (rs_hit) begin
                    tbl[rs_set][rs_way].chist <= rs_chist_n;
                    if (rs_taken)
                        tbl[rs_set][rs_way].tgt <= rs_target;
                    if (rs_mispredict) begin
                        tbl[rs_set][rs_way].shist <= rs_chist_n;
                        tbl[rs_set][rs_way].sval  <= 1'b0;
                    end
                end else begin
                    tbl[rs_set][rs_victim] <= rs_fresh;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_valid <= 1'b0;
            pred_hit   <= 1'b0;
            pred_taken <= 1'b0;
            pred_next  <= '0;
        end else begin
            pred_valid <= lk_valid;
            pred_hit   <= lk_valid && lk_hit;
            pred_taken <= lk_valid && lk_tk;
            pred_next  <= lk_tk ? lk_slot.tgt : lk_addr + FALL_STEP;
        end
    end

endmodule

// File: rtl/btb_chk.sv
module btb_chk
    import btb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              pred_valid,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_next,
    input logic [WAYS-1:0]   lk_hitv,
    input logic [WAYS-1:0]   rs_hitv
);

    // R2
    pv_follow_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> pred_valid);

    // R2
    pv_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !pred_valid);

    // R3
    miss_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && !pred_hit) |-> (!pred_taken && pred_next == $past(lk_addr) + FALL_STEP));

    // R4
    taken_hit_chk: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> (pred_hit && pred_valid));

    // R4
    lk_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hitv));

    // R10
    rs_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rs_hitv));

endmodule

bind btb_two_level btb_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .lk_addr    (lk_addr),
    .pred_valid (pred_valid),
    .pred_hit   (pred_hit),
    .pred_taken (pred_taken),
    .pred_next  (pred_next),
    .lk_hitv    (lk_hitv),
    .rs_hitv    (rs_hitv)
);

// File: tb/sim_btb_two_level.sv
`timescale 1ns/1ps
module sim_btb_two_level;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_addr = '0;
    logic        rs_taken = 1'b0;
    logic [31:0] rs_target = '0;
    logic        rs_mispredict = 1'b0;
    logic        pred_valid, pred_hit, pred_taken;
    logic [31:0] pred_next;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    btb_two_level u0 (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
        .rs_target(rs_target), .rs_mispredict(rs_mispredict),
        .pred_valid(pred_valid), .pred_hit(pred_hit),
        .pred_taken(pred_taken), .pred_next(pred_next)
    );

    // reference state
    bit        m_vld [128][4];
    bit [20:0] m_tag [128][4];
    bit [3:0]  m_off [128][4];
    bit [31:0] m_tgt [128][4];
    bit [3:0]  m_ch  [128][4];
    bit [3:0]  m_sh  [128][4];
    bit        m_sv  [128][4];
    int        m_age [128][4];
    int        m_pht [128][16];

    function automatic void model_reset();
        for (int s = 0; s < 128; s++) begin
            for (int w = 0; w < 4; w++) begin
                m_vld[s][w] = 0; m_tag[s][w] = '0; m_off[s][w] = '0;
                m_tgt[s][w] = '0; m_ch[s][w] = '0; m_sh[s][w] = '0;
                m_sv[s][w] = 0; m_age[s][w] = w;
            end
            for (int h = 0; h < 16; h++) m_pht[s][h] = 1;
        end
    endfunction

    function automatic int find(input bit [31:0] a);
        int s = int'(a[10:4]);
        for (int w = 0; w < 4; w++)
            if (m_vld[s][w] && m_tag[s][w] == a[31:11] && m_off[s][w] == a[3:0])
                return w;
        return -1;
    endfunction

    function automatic void touch(input int s, input int w);
        int a = m_age[s][w];
        for (int v = 0; v < 4; v++) begin
            if (v == w) m_age[s][v] = 0;
            else if (m_age[s][v] < a) m_age[s][v] = m_age[s][v] + 1;
        end
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit lv, input bit [31:0] la,
                        input bit rv, input bit [31:0] ra, input bit rt,
                        input bit [31:0] rtg, input bit rm, input string req);
        bit e_hit, e_tk;
        bit [31:0] e_next;
        bit [3:0] h;
        int ls, lw, rs, rw, vic;
        ls = int'(la[10:4]);
        lw = find(la);
        e_hit = lv && (lw >= 0);
        e_tk = 0;
        e_next = la + 32'd4;
        if (e_hit) begin
            h = m_sv[ls][lw] ? m_sh[ls][lw] : m_ch[ls][lw];
            e_tk = m_pht[ls][h] >= 2;
            if (e_tk) e_next = m_tgt[ls][lw];
        end
        // resolve search sees pre-edge state
        rs = int'(ra[10:4]);
        rw = find(ra);
        if (e_hit) begin
            m_sh[ls][lw] = {h[2:0], e_tk};
            m_sv[ls][lw] = 1;
        end
        if (rv) begin
            if (rw >= 0) begin
                bit [3:0] nc = {m_ch[rs][rw][2:0], rt};
                int c = m_pht[rs][m_ch[rs][rw]];
                m_pht[rs][m_ch[rs][rw]] = rt ? ((c == 3) ? 3 : c + 1) : ((c == 0) ? 0 : c - 1);
                m_ch[rs][rw] = nc;
                if (rt) m_tgt[rs][rw] = rtg;
                if (rm) begin m_sh[rs][rw] = nc; m_sv[rs][rw] = 0; end
                touch(rs, rw);
            end else begin
                vic = 0;
                for (int w = 0; w < 4; w++) if (m_age[rs][w] == 3) vic = w;
                m_vld[rs][vic] = 1; m_tag[rs][vic] = ra[31:11]; m_off[rs][vic] = ra[3:0];
                m_tgt[rs][vic] = rtg; m_ch[rs][vic] = '0; m_sh[rs][vic] = '0;
                m_sv[rs][vic] = 0;
                touch(rs, vic);
            end
        end
        lk_valid = lv; lk_addr = la;
        rs_valid = rv; rs_addr = ra; rs_taken = rt; rs_target = rtg; rs_mispredict = rm;
        @(negedge clk);
        lk_valid = 0; rs_valid = 0; rs_mispredict = 0; rs_taken = 0;
        if (lv) begin
            check(pred_valid == 1'b1, req, "pred_valid", {31'd0, pred_valid}, 32'd1);
            check(pred_hit == e_hit, req, "pred_hit", {31'd0, pred_hit}, {31'd0, e_hit});
            check(pred_taken == e_tk, req, "pred_taken", {31'd0, pred_taken}, {31'd0, e_tk});
            check(pred_next == e_next, req, "pred_next", pred_next, e_next);
        end else begin
            check(pred_valid == 1'b0, req, "pred_valid idle", {31'd0, pred_valid}, 32'd0);
        end
    endtask

    function automatic bit [31:0] mk(input int set, input int tag, input int off);
        return {21'(tag), 7'(set), 4'(off)};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit [31:0] a, b;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check(pred_valid == 1'b0, "R1", "pred_valid after reset", {31'd0, pred_valid}, 32'd0);

        a = mk(5, 100, 8);
        step(1, a, 0, 0, 0, 0, 0, "R3");                   // R3 miss falls through
        step(0, 0, 1, a, 1, 32'h4000_0000, 1, "R2");       // R10 allocate, R2 idle
        step(1, a, 0, 0, 0, 0, 0, "R1 R4");                // counter starts weak not-taken
        step(0, 0, 1, a, 1, 32'h4000_0000, 0, "R7");       // train counter at history 0
        step(1, a, 0, 0, 0, 0, 0, "R5");                   // speculative history 0 -> taken
        step(1, a, 0, 0, 0, 0, 0, "R6");                   // spec history advanced
        step(0, 0, 1, a, 0, 0, 1, "R8");                   // mispredict recovery
        step(1, a, 0, 0, 0, 0, 0, "R8");
        step(1, a, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 1, a, 1, 32'h5000_0010, 0, "R7");       // new target
        step(0, 0, 1, a, 1, 32'h5000_0010, 0, "R7");
        step(1, a, 1, a, 1, 32'h5000_0020, 1, "R12");      // same entry, same cycle
        step(1, a, 0, 0, 0, 0, 0, "R12");
        // R11: four more branches into set 5 evict the oldest
        for (int i = 1; i <= 4; i++) begin
            b = mk(5, 100 + i, 8);
            step(0, 0, 1, b, 1, 32'h6000_0000 + i, 0, "R10");
        end
        step(1, a, 0, 0, 0, 0, 0, "R11");
        step(1, mk(5, 101, 8), 0, 0, 0, 0, 0, "R11");
        step(1, mk(5, 104, 8), 0, 0, 0, 0, 0, "R11");

        // random traffic on two contended sets
        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            bit [31:0] la, ra;
            la = mk(($urandom % 2) ? 9 : 3, $urandom % 6, ($urandom % 2) * 8);
            ra = mk(($urandom % 2) ? 9 : 3, $urandom % 6, ($urandom % 2) * 8);
            step(($urandom % 4) != 0, la, ($urandom % 3) == 0, ra, $urandom % 2,
                 $urandom & 32'hFFFF_FFFC, ($urandom % 4) == 0, "R4 R5 R6 R7 R12");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule